// File: doc/BRIEF.md
# Half-Bridge PWM Channel with Shutdown Control

This block is one phase of a multi-phase PWM power stage. It owns no counter: a free-running period counter that all phases share arrives on an input, along with two strobes from the shared counter logic. One strobe marks the last tick of a period, when new settings may be taken. The other marks the first tick of the next period, when they take effect. The channel compares the shared count against its own duty value and drives two outputs. One is the positive (high-side) drive. The other is a gate-enable line that holds the transistor pair out of shutdown.

Settings pass through two register stages. A shadow stage captures the duty value and the two enable bits on every cycle the load strobe is high. An active stage copies the shadow stage when the restart strobe arrives. A host can therefore write settings at any time without tearing a period in progress. A failsafe input overrides everything combinationally and turns both outputs off. The stored settings are left intact, so the outputs resume once failsafe drops.

Top module: `pwm_halfbridge_chan`

## Requirements
- R1: While reset is asserted, and until a load followed by a restart has taken place afterwards, `drive_o` and `gate_o` are 0. Reset clears both the shadow and active stages to duty 0 with both enables 0.
- R2: The shadow stage takes `duty_i`, `drv_en_i` and `sd_en_i` at each rising clock edge where `load_i` is 1. Values on those inputs while `load_i` is 0 have no effect on either output in any later period.
- R3: The active stage takes the shadow contents at each rising edge where `restart_i` is 1, and holds them otherwise. In the cycle where `restart_i` is 1, the outputs already follow the shadow contents. If `load_i` and `restart_i` are high together, the active stage receives the shadow value from before that edge, and the newly loaded value waits for the next restart.
- R4: `drive_o` is 1 exactly when the governing positive-enable bit is 1 and `count_i` is strictly less than the governing duty value. It is therefore high from count 0 until the count equals the duty value, and low from that tick to the end of the period. A duty of 0 keeps it low for the whole period.
- R5: `gate_o` equals the governing shutdown-enable bit. A 1 releases the stage from shutdown, and a 0 holds it in shutdown.
- R6: While `failsafe_i` is 1, `drive_o` and `gate_o` are 0 in the same cycle, whatever the other inputs are. Stored settings are unchanged by failsafe, and the outputs follow them again in the first cycle after it drops.
- R7: Count and duty width is the parameter `CNT_W` (default 11), so a period spans 2^CNT_W ticks. A duty of 2^CNT_W-1 keeps the drive high on every tick except the last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| count_i | input | CNT_W | Shared period counter value |
| restart_i | input | 1 | One-cycle strobe: counter is at zero, new period begins |
| load_i | input | 1 | Strobe: last tick of the period, settings are sampled |
| duty_i | input | CNT_W | Duty (match) value to be loaded |
| drv_en_i | input | 1 | Positive-drive enable to be loaded |
| sd_en_i | input | 1 | Shutdown-release enable to be loaded |
| failsafe_i | input | 1 | Forces both outputs off, combinationally |
| drive_o | output | 1 | Positive (high-side) drive |
| gate_o | output | 1 | Gate enable, 1 = out of shutdown |

## Verification
Two functions can coincide in one cycle: the shadow capture and the shadow-to-active copy. The bench provokes this by raising `load_i` and `restart_i` together with a fresh duty value. It then expects the old shadow value to govern the following period and the fresh value only the period after the next restart. Failsafe is also dropped onto a restart tick, and the first tick after release must show the newly promoted settings. Every tick of every period in a full sweep of duty and enable values, at a 4-bit counter width, is compared against a model computed from the requirements.

// File: rtl/pwmch_pkg.sv
package pwmch_pkg;

  // Default width of the shared period counter and of the duty value.
  localparam int unsigned DEF_CNT_W = 11;

  // Per-channel enable pair carried through both register stages.
  typedef struct packed {
    logic drv_en;  // positive drive allowed
    logic sd_en;   // stage released from shutdown
  } pwmch_en_t;

endpackage

// File: rtl/pwmch_rst_sync.sv
module pwmch_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [1:0] stage_q;

  // Asserts asynchronously, deasserts after two clock edges.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_no = stage_q[1];

endmodule

// File: rtl/pwmch_cfg_buf.sv
module pwmch_cfg_buf
  import pwmch_pkg::*;
#(
  parameter int unsigned CNT_W = DEF_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             restart_i,
  input  pwmch_en_t        en_i,
  input  logic [CNT_W-1:0] duty_i,
  output pwmch_en_t        en_eff_o,
  output logic [CNT_W-1:0] duty_eff_o
);

  pwmch_en_t        sh_en_q,   sh_en_d;
  logic [CNT_W-1:0] sh_duty_q, sh_duty_d;
  pwmch_en_t        act_en_q,  act_en_d;
  logic [CNT_W-1:0] act_duty_q, act_duty_d;

  // Next-state: shadow follows the inputs under load, active follows shadow under restart.
  always_comb begin
    sh_en_d    = sh_en_q;
    sh_duty_d  = sh_duty_q;
    act_en_d   = act_en_q;
    act_duty_d = act_duty_q;
    if (load_i) begin
      sh_en_d   = en_i;
      sh_duty_d = duty_i;
    end
    if (restart_i) begin
      act_en_d   = sh_en_q;
      act_duty_d = sh_duty_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_en_q    <= '0;
      sh_duty_q  <= '0;
      act_en_q   <= '0;
      act_duty_q <= '0;
    end else begin
      sh_en_q    <= sh_en_d;
      sh_duty_q  <= sh_duty_d;
      act_en_q   <= act_en_d;
      act_duty_q <= act_duty_d;
    end
  end

  // On the restart tick the value about to be promoted already governs.
  assign en_eff_o   = restart_i ? sh_en_q   : act_en_q;
  assign duty_eff_o = restart_i ? sh_duty_q : act_duty_q;

  assert_shadow_hold_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(sh_duty_q) && $stable(sh_en_q)));

  assert_active_hold_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !restart_i |=> ($stable(act_duty_q) && $stable(act_en_q)));

  assert_restart_uses_shadow_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && restart_i) |=> (act_duty_q == $past(sh_duty_q)));

endmodule

// File: rtl/pwmch_out_stage.sv
module pwmch_out_stage
  import pwmch_pkg::*;
#(
  parameter int unsigned CNT_W = DEF_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] duty_i,
  input  pwmch_en_t        en_i,
  input  logic             failsafe_i,
  output logic             drive_o,
  output logic             gate_o
);

  logic below_match;

  assign below_match = (count_i < duty_i);

  // Failsafe overrides combinationally; no register on this path.
  always_comb begin
    drive_o = 1'b0;
    gate_o  = 1'b0;
    if (!failsafe_i) begin
      drive_o = en_i.drv_en & below_match;
      gate_o  = en_i.sd_en;
    end
  end

  assert_failsafe_off_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    failsafe_i |-> (!drive_o && !gate_o));

  assert_low_at_match_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_i == duty_i) |-> !drive_o);

  assert_drive_needs_enable_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_o |-> en_i.drv_en);

endmodule

// File: rtl/pwm_halfbridge_chan.sv
module pwm_halfbridge_chan
  import pwmch_pkg::*;
#(
  parameter int unsigned CNT_W = DEF_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] count_i,
  input  logic             restart_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic             drv_en_i,
  input  logic             sd_en_i,
  input  logic             failsafe_i,
  output logic             drive_o,
  output logic             gate_o
);

  logic             rst_sync_n;
  pwmch_en_t        en_in;
  pwmch_en_t        en_eff;
  logic [CNT_W-1:0] duty_eff;

  assign en_in.drv_en = drv_en_i;
  assign en_in.sd_en  = sd_en_i;

  pwmch_rst_sync u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  pwmch_cfg_buf #(.CNT_W(CNT_W)) u_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .load_i     (load_i),
    .restart_i  (restart_i),
    .en_i       (en_in),
    .duty_i     (duty_i),
    .en_eff_o   (en_eff),
    .duty_eff_o (duty_eff)
  );

  pwmch_out_stage #(.CNT_W(CNT_W)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .count_i    (count_i),
    .duty_i     (duty_eff),
    .en_i       (en_eff),
    .failsafe_i (failsafe_i),
    .drive_o    (drive_o),
    .gate_o     (gate_o)
  );

  // R1: nothing drives while the block is held in reset.
  assert_reset_quiet_R1 : assert property (@(posedge clk_i)
    !rst_sync_n |-> (!drive_o && !gate_o));

endmodule

// File: tb/pwm_halfbridge_chan_tb.sv
module pwm_halfbridge_chan_tb_top;

  localparam int unsigned W   = 4;
  localparam int unsigned MAXC = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] count, duty;
  logic         restart, load, drv_en, sd_en, failsafe;
  logic         drive, gate;

  int vectors = 0;
  int errors  = 0;

  // Reference state computed from the requirements.
  logic [W-1:0] m_sh_duty, m_act_duty;
  logic         m_sh_pe, m_sh_se, m_act_pe, m_act_se;
  // Inputs applied in the previous cycle.
  logic [W-1:0] p_duty;
  logic         p_ld, p_rs, p_pe, p_se;

  always #10 clk = ~clk;  // 50 MHz

  pwm_halfbridge_chan #(.CNT_W(W)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .count_i    (count),
    .restart_i  (restart),
    .load_i     (load),
    .duty_i     (duty),
    .drv_en_i   (drv_en),
    .sd_en_i    (sd_en),
    .failsafe_i (failsafe),
    .drive_o    (drive),
    .gate_o     (gate)
  );

  task automatic check(input logic act, input logic exp, input string tag, input string what);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: count=%0d actual=%b expected=%b", tag, what, count, act, exp);
    end
  endtask

  task automatic model_clear();
    m_sh_duty = '0; m_act_duty = '0;
    m_sh_pe = 0; m_sh_se = 0; m_act_pe = 0; m_act_se = 0;
    p_duty = '0; p_ld = 0; p_rs = 0; p_pe = 0; p_se = 0;
  endtask

  // One clock cycle: update the model for the last edge, apply inputs, check mid-cycle.
  task automatic cyc(input logic [W-1:0] cnt, input logic ld, input logic rs,
                     input logic fs, input logic pe, input logic se,
                     input logic [W-1:0] du, input string dtag, input string gtag);
    logic [W-1:0] eff_d;
    logic eff_pe, eff_se, exp_d, exp_g;
    @(posedge clk);
    #1;
    if (p_rs) begin
      m_act_duty = m_sh_duty; m_act_pe = m_sh_pe; m_act_se = m_sh_se;
    end
    if (p_ld) begin
      m_sh_duty = p_duty; m_sh_pe = p_pe; m_sh_se = p_se;
    end
    count = cnt; load = ld; restart = rs; failsafe = fs;
    drv_en = pe; sd_en = se; duty = du;
    p_ld = ld; p_rs = rs; p_pe = pe; p_se = se; p_duty = du;
    #8;
    eff_d  = rs ? m_sh_duty : m_act_duty;
    eff_pe = rs ? m_sh_pe   : m_act_pe;
    eff_se = rs ? m_sh_se   : m_act_se;
    exp_d  = !fs && eff_pe && (cnt < eff_d);
    exp_g  = !fs && eff_se;
    check(drive, exp_d, dtag, "drive");
    check(gate,  exp_g, gtag, "gate");
  endtask

  // One full period; settings presented on the load tick, noise elsewhere.
  task automatic period(input logic pe, input logic se, input logic [W-1:0] du,
                        input int fs_tick, input string dtag, input string gtag);
    for (int c = 0; c <= int'(MAXC); c++) begin
      logic last;
      last = (c == int'(MAXC));
      cyc(W'(c), last, (c == 0), (c == fs_tick),
          last ? pe : ~pe, last ? se : ~se, last ? du : ~du, dtag, gtag);
    end
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    count = '0; duty = '0; restart = 0; load = 0;
    drv_en = 0; sd_en = 0; failsafe = 0;
    model_clear();

    // R1: inputs active during reset leave outputs off and nothing stored.
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1;
      count = W'(i); load = 1; restart = (i == 2); duty = '1; drv_en = 1; sd_en = 1;
      #8;
      check(drive, 1'b0, "R1", "drive in reset");
      check(gate,  1'b0, "R1", "gate in reset");
    end
    @(posedge clk); #1;
    load = 0; restart = 0; duty = '0; drv_en = 0; sd_en = 0;
    rst_n = 1'b1;
    model_clear();
    for (int i = 0; i < 4; i++) cyc('0, 0, 0, 0, 0, 0, '0, "R1", "R1");
    // First period after reset: active stage still cleared.
    period(1, 1, W'(9), -1, "R1", "R1");

    // R4/R5/R7 (with R2 noise off the load tick): every duty and enable pair.
    for (int d = 0; d <= int'(MAXC); d++) begin
      for (int e = 0; e < 4; e++) begin
        period(e[1], e[0], W'(d), -1, (d == int'(MAXC)) ? "R7" : "R4", "R5");
      end
    end
    period(0, 0, '0, -1, "R4", "R5");

    // R2: settings changed only while load is low must not appear.
    period(1, 1, W'(6), -1, "R2", "R2");
    for (int c = 0; c <= int'(MAXC); c++)
      cyc(W'(c), 0, (c == 0), 0, 1, 0, W'(13), "R2", "R2");
    period(1, 1, W'(6), -1, "R2", "R2");

    // R3: load and restart in the same cycle.
    cyc('0, 1, 1, 0, 1, 1, W'(3), "R3", "R3");
    for (int c = 1; c <= int'(MAXC); c++) cyc(W'(c), 0, 0, 0, 0, 0, '0, "R3", "R3");
    for (int c = 0; c <= int'(MAXC); c++) cyc(W'(c), 0, (c == 0), 0, 0, 0, '0, "R3", "R3");
    period(1, 0, W'(11), -1, "R3", "R3");
    // R3: a restart in the middle of a period promotes at once.
    for (int c = 0; c < 5; c++) cyc(W'(c), (c == 2), 0, 0, 1, 1, W'(14), "R3", "R3");
    cyc(W'(5), 0, 1, 0, 0, 0, '0, "R3", "R3");
    for (int c = 6; c <= int'(MAXC); c++) cyc(W'(c), 0, 0, 0, 0, 0, '0, "R3", "R3");

    // R6: failsafe on various ticks, including the restart tick, and recovery.
    for (int t = 0; t <= int'(MAXC); t += 3) period(1, 1, W'(10), t, "R6", "R6");
    for (int c = 0; c <= int'(MAXC); c++)
      cyc(W'(c), (c == int'(MAXC)), (c == 0), (c < 8), 1, 1, W'(15), "R6", "R6");
    period(1, 1, W'(4), -1, "R6", "R6");
    period(1, 1, W'(4), -1, "R6", "R6");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule